// File: doc/BRIEF.md
# Link Interrupt Status and Mask Unit

This unit collects event pulses from the parts of a serial-bus link controller (phy interface, transmitters, receiver, command decoder) into one 32-bit interrupt status register, and pairs it with a 32-bit enable register. Each recognised source owns one status bit. A one-cycle pulse from that source sets the bit, and the bit stays set until the host clears it. The host clears a bit by writing a one to it with chip-select and write strobe asserted.

Bit 0 of the status word is not stored. It is the OR of every pending bit whose enable bit is set, formed when the register is read. The `irq_o` output is a registered, active-high copy of that summary. The unit also shapes the receive-data event. In normal operation every accepted receive quadlet sets the receive-data bit. While the self-identification phase of a bus reset is in progress, only the quadlet that completes a self-ID packet sets it.

Top module: `link_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the status register reads 0, the enable register reads 0 and `irq_o` is 0.
- R2: A one-cycle pulse on a source sets its status bit at that clock edge, and the bit stays set on later cycles. The fixed bit positions are: phy interrupt = 1, phy register data = 2, phy reset started = 3, transmitter ready = 5, receive data = 6, command reset = 7, isochronous transmit stuck = 11, asynchronous transmit stuck = 12.
- R3: Bits 4, 8 to 10 and 13 to 31 read as zero in both registers, even after ones are written to them. Bit 0 of the enable register also reads as zero.
- R4: A write with `cs`=1, `wr`=1 and `addr`=0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged, and writing to bit 0 has no effect.
- R5: If a source pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: A write with `cs`=0 or with `wr`=0 changes neither register.
- R7: A write with `cs`=1, `wr`=1 and `addr`=1 loads the enable register, and its implemented bits read back as written.
- R8: With `addr`=0, `rdata` bit 0 is 1 exactly when some status bit and the matching enable bit are both 1. This value is combinational on the register contents.
- R9: `irq_o` equals the value that bit 0 of the status word had one clock earlier.
- R10: When `rx_selfid`=0, every `rx_quadlet` pulse sets status bit 6.
- R11: When `rx_selfid`=1, status bit 6 is set only by an `rx_quadlet` pulse that comes together with `rx_pkt_last`=1. A quadlet pulse alone, or `rx_pkt_last` alone, leaves the bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Host chip-select |
| wr | input | 1 | Host write strobe |
| addr | input | 1 | Register select: 0 = status, 1 = enable |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data for the selected register |
| irq_o | output | 1 | Registered interrupt request, active high |
| ev_phy_int | input | 1 | Pulse: the phy signalled an interrupt |
| ev_phy_reg | input | 1 | Pulse: phy register data arrived |
| ev_phy_rst | input | 1 | Pulse: bus reconfiguration started |
| ev_tx_ready | input | 1 | Pulse: transmitter became idle |
| ev_cmd_reset | input | 1 | Pulse: reset command write received |
| ev_iso_stuck | input | 1 | Pulse: isochronous transmit saw bad data |
| ev_async_stuck | input | 1 | Pulse: asynchronous transmit saw bad data or underflow |
| rx_quadlet | input | 1 | Pulse: receiver accepted one quadlet |
| rx_pkt_last | input | 1 | Marks the accepted quadlet as the last one of its packet |
| rx_selfid | input | 1 | Level: bus reset self-ID phase in progress |

## Verification
A source pulse and a host clear on the same bit can land on the same clock edge. The bench causes this for every implemented bit: it first sets the bit, then drives the pulse and a write-one-to-clear of that bit in one cycle. The bit must read back set, and it must clear on a later write that has no competing pulse. The same sweep also places an enable-register write in the cycle before an `irq_o` check. This shows that the summary bit changes at once while `irq_o` changes one edge later.

// File: rtl/link_irq_pkg.sv
// Package: bit positions, implemented-bit map and register select codes
// shared by the interrupt unit and its submodules.
package link_irq_pkg;
    localparam int REG_W = 32;

    localparam int B_SUMMARY   = 0;
    localparam int B_PHY_INT   = 1;
    localparam int B_PHY_REG   = 2;
    localparam int B_PHY_RST   = 3;
    localparam int B_TX_READY  = 5;
    localparam int B_RX_DATA   = 6;
    localparam int B_CMD_RESET = 7;
    localparam int B_ISO_STUCK = 11;
    localparam int B_ASY_STUCK = 12;

    // Bits that hold a stored flag. The summary bit and the reserved bits are excluded.
    localparam logic [REG_W-1:0] IMPL_BITS =
        (REG_W'(1) << B_PHY_INT)   | (REG_W'(1) << B_PHY_REG)  |
        (REG_W'(1) << B_PHY_RST)   | (REG_W'(1) << B_TX_READY) |
        (REG_W'(1) << B_RX_DATA)   | (REG_W'(1) << B_CMD_RESET) |
        (REG_W'(1) << B_ISO_STUCK) | (REG_W'(1) << B_ASY_STUCK);

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_rx_cond.sv
// Receive-data event conditioner.
// Does: produces one set pulse for the receive-data status bit. Every
//   accepted quadlet gives a pulse in normal mode. During the self-ID phase
//   only the quadlet that ends a packet gives a pulse.
// Assumes: quad_i is a one-cycle pulse per accepted quadlet; last_i is valid
//   together with quad_i; selfid_i is a level and is stable around packets.
module irq_rx_cond (
    input  logic quad_i,
    input  logic last_i,
    input  logic selfid_i,
    output logic set_o
);
    // Select per-quadlet or per-packet granularity from the bus-reset phase.
    always_comb begin
        if (selfid_i) set_o = quad_i & last_i;
        else          set_o = quad_i;
    end
endmodule

// File: rtl/irq_status_bank.sv
// Status and enable register bank.
// Does: keeps one sticky flag per implemented bit. A set pulse takes
//   priority over a write-one-to-clear in the same cycle. Also keeps the
//   enable bits and drives the combined pending flag.
// Assumes: set_i and clr_i are already decoded per bit; unimplemented bits
//   are tied to zero here, so no caller needs to filter them.
module irq_status_bank #(
    parameter int                 W    = 32,
    parameter logic [W-1:0]       IMPL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         pending_o
);
    logic [W-1:0] stat_q, stat_d;
    logic [W-1:0] en_q, en_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            assign stat_d[i] = set_i[i] | (stat_q[i] & ~clr_i[i]);
            assign en_d[i]   = en_we_i ? en_wdata_i[i] : en_q[i];

            // R5 / R2: a set pulse always leaves the flag set on the next cycle.
            a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> stat_q[i]);
            // R4: a clear with no competing set leaves the flag low.
            a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !stat_q[i]);
        end else begin : g_tied
            assign stat_d[i] = 1'b0;
            assign en_d[i]   = 1'b0;
        end
    end

    // Register update for flags and enables, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            en_q   <= en_d;
        end
    end

    // Combined pending flag across all enabled flags.
    always_comb pending_o = |(stat_q & en_q);

    assign stat_o = stat_q;
    assign en_o   = en_q;

    // R6: the enable register holds whenever no enable write is decoded.
    a_r6_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we_i |=> $stable(en_q));
endmodule

// File: rtl/link_irq_unit.sv
// Link interrupt status and enable unit (top).
// Does: gathers the event pulses into the status register, decodes host
//   writes (clear on status, load on enable), serves reads by address with
//   the summary formed in bit 0, and registers the interrupt request.
// Assumes: event inputs are one-cycle pulses synchronous to clk; host reads
//   need no strobe; reads are combinational on addr.
module link_irq_unit
    import link_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq_o,
    input  logic              ev_phy_int,
    input  logic              ev_phy_reg,
    input  logic              ev_phy_rst,
    input  logic              ev_tx_ready,
    input  logic              ev_cmd_reset,
    input  logic              ev_iso_stuck,
    input  logic              ev_async_stuck,
    input  logic              rx_quadlet,
    input  logic              rx_pkt_last,
    input  logic              rx_selfid
);
    localparam int W = REG_W;

    logic           rx_set;
    logic [W-1:0]   set_vec;
    logic [W-1:0]   clr_vec;
    logic           en_we;
    logic           wr_hit;
    logic [W-1:0]   stat;
    logic [W-1:0]   en;
    logic           pending;
    logic           irq_q;

    irq_rx_cond u_rx_cond (
        .quad_i   (rx_quadlet),
        .last_i   (rx_pkt_last),
        .selfid_i (rx_selfid),
        .set_o    (rx_set)
    );

    // Put each event pulse at its fixed bit position.
    always_comb begin
        set_vec              = '0;
        set_vec[B_PHY_INT]   = ev_phy_int;
        set_vec[B_PHY_REG]   = ev_phy_reg;
        set_vec[B_PHY_RST]   = ev_phy_rst;
        set_vec[B_TX_READY]  = ev_tx_ready;
        set_vec[B_RX_DATA]   = rx_set;
        set_vec[B_CMD_RESET] = ev_cmd_reset;
        set_vec[B_ISO_STUCK] = ev_iso_stuck;
        set_vec[B_ASY_STUCK] = ev_async_stuck;
    end

    // Decode host writes into a per-bit clear mask and an enable load strobe.
    always_comb begin
        wr_hit  = cs & wr;
        clr_vec = (wr_hit && reg_sel_e'(addr) == SEL_STATUS) ? wdata : '0;
        en_we   = wr_hit && reg_sel_e'(addr) == SEL_ENABLE;
    end

    irq_status_bank #(
        .W    (W),
        .IMPL (IMPL_BITS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_i      (clr_vec),
        .en_we_i    (en_we),
        .en_wdata_i (wdata),
        .stat_o     (stat),
        .en_o       (en),
        .pending_o  (pending)
    );

    // Read mux; the summary is ORed into bit 0 of the status word.
    always_comb begin
        if (reg_sel_e'(addr) == SEL_STATUS)
            rdata = stat | {{(W-1){1'b0}}, pending};
        else
            rdata = en;
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pending;
    end

    assign irq_o = irq_q;

    // R9: an enabled pending flag raises the request on the next cycle.
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & en) != '0) |=> irq_o);
    // R9: without any enabled pending flag the request is low next cycle.
    a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & en) == '0) |=> !irq_o);
    // R11: during self-ID a quadlet that does not end a packet sets nothing.
    a_r11_selfid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_selfid && rx_quadlet && !rx_pkt_last && !stat[B_RX_DATA])
        |=> !stat[B_RX_DATA]);
    // R3: reserved positions never hold a one in either register.
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat | en) & ~IMPL_BITS) == '0);
endmodule

// File: tb/test_link_irq_unit.sv
// Bench for link_irq_unit. It sweeps every register bit and every event
// source, and it checks against a model kept in the bench.
module test_link_irq_unit;
    localparam logic [31:0] IMPL = 32'h0000_18EE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 0, wr = 0, addr = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;
    logic        ev_phy_int = 0, ev_phy_reg = 0, ev_phy_rst = 0, ev_tx_ready = 0;
    logic        ev_cmd_reset = 0, ev_iso_stuck = 0, ev_async_stuck = 0;
    logic        rx_quadlet = 0, rx_pkt_last = 0, rx_selfid = 0;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_stat = '0;
    logic [31:0] m_en = '0;
    int ev_bits[8] = '{1, 2, 3, 5, 6, 7, 11, 12};

    link_irq_unit i_link_irq_unit (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
        .ev_phy_int(ev_phy_int), .ev_phy_reg(ev_phy_reg), .ev_phy_rst(ev_phy_rst),
        .ev_tx_ready(ev_tx_ready), .ev_cmd_reset(ev_cmd_reset),
        .ev_iso_stuck(ev_iso_stuck), .ev_async_stuck(ev_async_stuck),
        .rx_quadlet(rx_quadlet), .rx_pkt_last(rx_pkt_last), .rx_selfid(rx_selfid)
    );

    always #2 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return m_stat | {31'b0, |(m_stat & m_en)};
    endfunction

    task automatic drive_ev(int b, logic v);
        case (b)
            1:  ev_phy_int     = v;
            2:  ev_phy_reg     = v;
            3:  ev_phy_rst     = v;
            5:  ev_tx_ready    = v;
            6:  rx_quadlet     = v;
            7:  ev_cmd_reset   = v;
            11: ev_iso_stuck   = v;
            12: ev_async_stuck = v;
            default: ;
        endcase
    endtask

    // One clock: inputs set before this call are taken at the posedge, and the strobes are dropped at the next negedge.
    task automatic tick();
        @(negedge clk);
        cs = 0; wr = 0; wdata = '0; rx_pkt_last = 0;
        foreach (ev_bits[k]) drive_ev(ev_bits[k], 1'b0);
    endtask

    task automatic host_wr(logic a, logic [31:0] d);
        cs = 1; wr = 1; addr = a; wdata = d;
        tick();
    endtask

    task automatic rd(logic a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        rd(0, v); check("R1 status", v, 32'h0);
        rd(1, v); check("R1 enable", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        // R7 / R3: walking one through the enable register
        for (int k = 0; k < 32; k++) begin
            host_wr(1, 32'h1 << k);
            rd(1, v);
            check($sformatf("R7 R3 enable bit %0d", k), v, (32'h1 << k) & IMPL);
        end
        host_wr(1, 32'hFFFF_FFFF);
        rd(1, v); check("R3 enable all ones", v, IMPL);
        host_wr(1, 32'h0);

        // R6: writes with only one strobe are ignored
        cs = 1; wr = 0; addr = 1; wdata = 32'hFFFF_FFFF; tick();
        cs = 0; wr = 1; addr = 1; wdata = 32'hFFFF_FFFF; tick();
        rd(1, v); check("R6 enable unchanged", v, 32'h0);

        // R2 / R8: each source sets its bit, flags stay set, summary stays low while masked
        foreach (ev_bits[k]) begin
            drive_ev(ev_bits[k], 1'b1); tick();
            m_stat[ev_bits[k]] = 1'b1;
            tick();
            rd(0, v); check($sformatf("R2 R8 set bit %0d", ev_bits[k]), v, exp_status());
        end
        rd(0, v); check("R3 status only implemented", v, IMPL);
        check("R9 irq masked", {31'b0, irq_o}, 32'h0);

        // R6: status clear with only one strobe is ignored
        cs = 1; wr = 0; addr = 0; wdata = 32'hFFFF_FFFF; tick();
        cs = 0; wr = 1; addr = 0; wdata = 32'hFFFF_FFFF; tick();
        rd(0, v); check("R6 status unchanged", v, exp_status());

        // R8 / R9: enable one bit at a time; summary at once, irq one edge later
        foreach (ev_bits[k]) begin
            host_wr(1, 32'h1 << ev_bits[k]);
            m_en = 32'h1 << ev_bits[k];
            rd(0, v); check($sformatf("R8 summary bit %0d", ev_bits[k]), v, exp_status());
            @(negedge clk);
            check($sformatf("R9 irq bit %0d", ev_bits[k]), {31'b0, irq_o}, 32'h1);
            host_wr(1, 32'h0);
            m_en = '0;
            check("R9 irq still high one edge after disable", {31'b0, irq_o}, 32'h1);
            @(negedge clk);
            check("R9 irq low", {31'b0, irq_o}, 32'h0);
        end

        // R4: write-one-to-clear per bit, bit 0 write has no effect
        host_wr(1, IMPL); m_en = IMPL;
        host_wr(0, 32'h1);
        rd(0, v); check("R4 bit0 write ignored", v, exp_status());
        foreach (ev_bits[k]) begin
            host_wr(0, 32'h1 << ev_bits[k]);
            m_stat[ev_bits[k]] = 1'b0;
            rd(0, v); check($sformatf("R4 clear bit %0d", ev_bits[k]), v, exp_status());
        end
        @(negedge clk);
        check("R9 irq low after clears", {31'b0, irq_o}, 32'h0);

        // R5: set and clear in one cycle, the set wins
        foreach (ev_bits[k]) begin
            drive_ev(ev_bits[k], 1'b1); tick();
            drive_ev(ev_bits[k], 1'b1);
            host_wr(0, 32'h1 << ev_bits[k]);
            m_stat[ev_bits[k]] = 1'b1;
            rd(0, v); check($sformatf("R5 collide bit %0d", ev_bits[k]), v, exp_status());
            host_wr(0, 32'h1 << ev_bits[k]);
            m_stat[ev_bits[k]] = 1'b0;
            rd(0, v); check($sformatf("R4 later clear bit %0d", ev_bits[k]), v, exp_status());
        end

        // R10: normal mode, every quadlet sets bit 6
        rx_selfid = 0;
        for (int q = 0; q < 4; q++) begin
            rx_quadlet = 1; rx_pkt_last = (q == 3); tick();
            rd(0, v); check($sformatf("R10 quadlet %0d", q), v & 32'h40, 32'h40);
            host_wr(0, 32'h40);
        end

        // R11: self-ID phase, only the packet-ending quadlet sets bit 6
        rx_selfid = 1;
        for (int q = 0; q < 3; q++) begin
            rx_quadlet = 1; rx_pkt_last = 0; tick();
            rd(0, v); check($sformatf("R11 mid quadlet %0d", q), v & 32'h40, 32'h0);
        end
        rx_quadlet = 0; rx_pkt_last = 1; tick();
        rd(0, v); check("R11 last without quadlet", v & 32'h40, 32'h0);
        rx_quadlet = 1; rx_pkt_last = 1; tick();
        rd(0, v); check("R11 packet end", v & 32'h40, 32'h40);
        rx_selfid = 0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule